// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates one virtual address at a time by walking a three-level page table held in memory. A translation is offered on a valid/ready input channel together with the root table address. The walker then issues one read per level on a simple memory port: a single-cycle request pulse with an address, answered some cycles later by a data-valid pulse carrying the 64-bit entry. It keeps going down the levels until an entry marks a leaf, and then reports that leaf.

A leaf found above the bottom level maps a large page. The walker merges the virtual page bits that the skipped levels would have indexed into the returned entry, so the caller always receives a translation for the exact 4 KiB page. Every failure returns an all-zero entry: a badly sign-extended address, an entry with its valid bit clear, a table pointer at the bottom level, or an entry address or final page base at or beyond the memory size. Permission checks, translation caching and accessed/dirty updates belong to the caller.

Back-pressure applies on the input side only. `in_ready` is high only while the walker is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. The result side has no back-pressure: `done` is a one-cycle pulse that the consumer must capture.

Top module: `pt_walker`

## Requirements
- R1: Out of reset `in_ready` is 1, `done` is 0 and `mem_req` is 0. `in_ready` is high exactly while no walk is in progress. `in_valid`, `in_vaddr` and `pt_root` are ignored while `in_ready` is low, and `in_vaddr`/`pt_root` are sampled only on the accepting edge.
- R2: If bits 63..38 of the accepted address are not all equal, `done` rises with a zero entry in the cycle after acceptance, and no memory request is made.
- R3: The first request appears in the cycle after acceptance. Level 0 is the top level. The request for level L has address base + 8*index, where index = vaddr[12+9*(2-L) +: 9]. The level-0 base is `pt_root`.
- R4: If a computed entry address is at or above `MEM_SIZE`, no request is issued. `done` then rises with a zero entry two cycles after the event that started that level (the acceptance or the data-valid).
- R5: An entry whose bit 0 (valid) is clear ends the walk with a zero entry. `done` rises in the cycle after `mem_rvalid`.
- R6: An entry at level 0 or 1 with bit 0 and bit 1 (table) both set points to the next level. The next base is the entry with bits 11..0 cleared, and the next request appears in the cycle after `mem_rvalid`.
- R7: A valid entry with bit 1 clear is a leaf found at level L. The result is the entry ORed with vaddr[12 +: 9*(2-L)] placed at bit 12. It appears with `done` in the cycle after `mem_rvalid`.
- R8: If a leaf result with bits 11..0 cleared is at or above `MEM_SIZE`, the result is a zero entry.
- R9: A table entry (bits 0 and 1 set) at level 2 ends the walk with a zero entry.
- R10: `done` is high for exactly one cycle per accepted walk, and `pte` is zero whenever `done` is low.
- R11: `mem_req` is a single-cycle pulse, with at most one read outstanding. A `mem_rvalid` that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_root | input | 64 | Root table address, sampled on acceptance |
| in_valid | input | 1 | Translation request valid |
| in_ready | output | 1 | Walker idle, request can be taken |
| in_vaddr | input | 64 | Virtual address to translate |
| done | output | 1 | One-cycle result pulse |
| pte | output | 64 | Leaf entry, or zero on failure; zero when `done` is low |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 64 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read from memory |

## Verification
The bench drives walks that end at each level: 4 KiB leaves, 2 MiB leaves and 1 GiB leaves. It checks that the merged page bits come from the right slice of the address. A design that took the wrong slice, or that merged bits for a bottom-level leaf, would return a wrong page. The bench also covers the case where merging pushes a large page past the memory end. A design that checked only the raw entry, rather than the merged result, would hand back a page outside memory.

Further cases cover an entry address that lands exactly at the memory size, a table pointer at the bottom level, negative canonical addresses, non-canonical addresses, and a stray data-valid. A design that read out of bounds, that kept walking past the last level, that rejected upper-half addresses, or that acted on unsolicited data would issue extra requests or report the wrong timing or result. Inputs are changed while a walk is busy and the result is then compared unchanged. This catches a walker that re-samples its address or root mid-walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_WAIT  = 2'd2
  } wk_state_e;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_TABLE_BIT = 1;

endpackage

// File: rtl/pt_canon_chk.sv
module pt_canon_chk #(
  parameter int AW   = 64,
  parameter int VA_W = 39
) (
  input  logic [AW-VA_W:0] va_hi,
  output logic             canon
);
  assign canon = (&va_hi) | ~(|va_hi);
endmodule

// File: rtl/pt_index_gen.sv
module pt_index_gen #(
  parameter int          AW        = 64,
  parameter int          LEVELS    = 3,
  parameter int          IDX_W     = 9,
  parameter int          PTE_BYTES = 8,
  parameter int          LVL_W     = 2,
  parameter logic [63:0] MEM_SIZE  = 64'h10_0000
) (
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  logic [AW-1:0]           base,
  input  logic [LVL_W-1:0]        level,
  output logic [AW-1:0]           ent_addr,
  output logic                    addr_ok
);
  localparam int          PTE_SHIFT = $clog2(PTE_BYTES);
  localparam logic [AW-1:0] MEM_LIM = AW'(MEM_SIZE);

  logic [IDX_W-1:0] idx_at [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    localparam int LO = (LEVELS - 1 - l) * IDX_W;
    assign idx_at[l] = vpn[LO +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) idx_sel = idx_at[l];
    end
  end

  assign ent_addr = base + (AW'(idx_sel) << PTE_SHIFT);
  assign addr_ok  = ent_addr < MEM_LIM;
endmodule

// File: rtl/pt_leaf_fold.sv
module pt_leaf_fold #(
  parameter int          AW       = 64,
  parameter int          LEVELS   = 3,
  parameter int          IDX_W    = 9,
  parameter int          PG_SHIFT = 12,
  parameter int          LVL_W    = 2,
  parameter logic [63:0] MEM_SIZE = 64'h10_0000
) (
  input  logic [(LEVELS-1)*IDX_W-1:0] vpn_low,
  input  logic [AW-1:0]               entry,
  input  logic [LVL_W-1:0]            level,
  output logic [AW-1:0]               folded,
  output logic                        page_ok
);
  localparam logic [AW-1:0] MEM_LIM = AW'(MEM_SIZE);

  logic [AW-1:0] fill_at [LEVELS];
  logic [AW-1:0] fill_sel;
  logic [AW-1:0] page_base;

  for (genvar l = 0; l < LEVELS; l++) begin : g_fill
    localparam int LOW = (LEVELS - 1 - l) * IDX_W;
    if (LOW == 0) begin : g_leaf4k
      assign fill_at[l] = '0;
    end else begin : g_super
      assign fill_at[l] = AW'(vpn_low[LOW-1:0]) << PG_SHIFT;
    end
  end

  always_comb begin
    fill_sel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) fill_sel = fill_at[l];
    end
  end

  assign folded    = entry | fill_sel;
  assign page_base = {folded[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign page_ok   = page_base < MEM_LIM;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int          AW        = 64,
  parameter int          VA_W      = 39,
  parameter int          LEVELS    = 3,
  parameter int          IDX_W     = 9,
  parameter int          PG_SHIFT  = 12,
  parameter int          PTE_BYTES = 8,
  parameter logic [63:0] MEM_SIZE  = 64'h10_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pt_root,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_vaddr,
  output logic          done,
  output logic [AW-1:0] pte,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata
);
  localparam int                 VPN_W  = LEVELS * IDX_W;
  localparam int                 FOLD_W = (LEVELS - 1) * IDX_W;
  localparam int                 LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0]   LAST   = LVL_W'(LEVELS - 1);

  wk_state_e        state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [AW-1:0]    base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             done_q;
  logic [AW-1:0]    pte_q;

  logic             canon;
  logic [AW-1:0]    ent_addr;
  logic             addr_ok;
  logic [AW-1:0]    folded;
  logic             page_ok;
  logic             unused_pgoff;

  assign unused_pgoff = ^in_vaddr[PG_SHIFT-1:0];

  pt_canon_chk #(.AW(AW), .VA_W(VA_W)) u_canon (
    .va_hi (in_vaddr[AW-1:VA_W-1]),
    .canon (canon)
  );

  pt_index_gen #(
    .AW(AW), .LEVELS(LEVELS), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES),
    .LVL_W(LVL_W), .MEM_SIZE(MEM_SIZE)
  ) u_index (
    .vpn      (vpn_q),
    .base     (base_q),
    .level    (lvl_q),
    .ent_addr (ent_addr),
    .addr_ok  (addr_ok)
  );

  pt_leaf_fold #(
    .AW(AW), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT),
    .LVL_W(LVL_W), .MEM_SIZE(MEM_SIZE)
  ) u_fold (
    .vpn_low (vpn_q[FOLD_W-1:0]),
    .entry   (mem_rdata),
    .level   (lvl_q),
    .folded  (folded),
    .page_ok (page_ok)
  );

  assign in_ready = (state_q == WK_IDLE);
  assign mem_req  = (state_q == WK_FETCH) && addr_ok;
  assign mem_addr = ent_addr;
  assign done     = done_q;
  assign pte      = pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      pte_q   <= '0;
    end else begin
      done_q <= 1'b0;
      pte_q  <= '0;
      unique case (state_q)
        WK_IDLE: begin
          if (in_valid) begin
            if (canon) begin
              vpn_q   <= in_vaddr[PG_SHIFT +: VPN_W];
              base_q  <= pt_root;
              lvl_q   <= '0;
              state_q <= WK_FETCH;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        WK_FETCH: begin
          if (addr_ok) begin
            state_q <= WK_WAIT;
          end else begin
            done_q  <= 1'b1;
            state_q <= WK_IDLE;
          end
        end
        WK_WAIT: begin
          if (mem_rvalid) begin
            if (!mem_rdata[PTE_VALID_BIT]) begin
              done_q  <= 1'b1;
              state_q <= WK_IDLE;
            end else if (mem_rdata[PTE_TABLE_BIT]) begin
              if (lvl_q == LAST) begin
                done_q  <= 1'b1;
                state_q <= WK_IDLE;
              end else begin
                base_q  <= {mem_rdata[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
                lvl_q   <= lvl_q + LVL_W'(1);
                state_q <= WK_FETCH;
              end
            end else begin
              done_q  <= 1'b1;
              pte_q   <= page_ok ? folded : '0;
              state_q <= WK_IDLE;
            end
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int          AW       = 64,
  parameter int          VA_W     = 39,
  parameter int          PG_SHIFT = 12,
  parameter logic [63:0] MEM_SIZE = 64'h10_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [AW-VA_W:0] va_hi,
  input logic            done,
  input logic [AW-1:0]   pte,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr
);
  localparam logic [AW-1:0] MEM_LIM = AW'(MEM_SIZE);

  logic bad_va;
  assign bad_va = !((&va_hi) || !(|va_hi));

  AST_REQ_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr < MEM_LIM)); // R4

  AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready); // R1

  AST_PTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (pte == '0)); // R10

  AST_LEAF_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pte != '0) |-> (pte[0] && !pte[1])); // R7

  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pte != '0) |-> ({pte[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}} < MEM_LIM)); // R8

  AST_NONCANON_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bad_va) |=> (done && pte == '0 && !mem_req)); // R2
endmodule

bind pt_walker pt_walker_chk #(
  .AW(AW), .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .MEM_SIZE(MEM_SIZE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .va_hi    (in_vaddr[AW-1:VA_W-1]),
  .done     (done),
  .pte      (pte),
  .mem_req  (mem_req),
  .mem_addr (mem_addr)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam logic [63:0] MEM_SZ = 64'h10_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pt_root = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_vaddr = '0;
  logic        done;
  logic [63:0] pte;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .pt_root(pt_root), .in_valid(in_valid),
    .in_ready(in_ready), .in_vaddr(in_vaddr), .done(done), .pte(pte),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] exp_q [$];
  logic [63:0] exp_pte;
  bit          exp_oob;
  string       cur_tag;
  int          cyc = 0;
  int          ev_cyc = 0;
  int          lat = 1;
  bit          active = 1'b0;
  bit          pending = 1'b0;
  int          resp_cyc = 0;
  logic [63:0] resp_data;
  bit          live = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem_img.exists(a) ? mem_img[a] : 64'h0;
  endfunction

  // behavioural translation model
  task automatic ref_walk(input logic [63:0] va, input logic [63:0] root);
    logic [63:0] base, pa, d, vpn;
    exp_q.delete();
    exp_oob = 1'b0;
    exp_pte = '0;
    if (!(va[63:38] == '0 || va[63:38] == '1)) return;
    base = root;
    vpn  = va >> 12;
    for (int i = 0; i < 3; i++) begin
      int sh = (2 - i) * 9;
      pa = base + (((va >> (12 + sh)) & 64'h1FF) * 8);
      if (pa >= MEM_SZ) begin exp_oob = 1'b1; return; end
      exp_q.push_back(pa);
      d = rd(pa);
      if (d[0] == 1'b0) return;
      if (d[1] == 1'b1) begin
        base = (d >> 12) << 12;
      end else begin
        d = d | ((vpn & ((64'd1 << sh) - 1)) << 12);
        if (((d >> 12) << 12) < MEM_SZ) exp_pte = d;
        return;
      end
    end
  endtask

  // per-clock comparison and memory responder
  always @(negedge clk) begin
    if (live) begin
      cyc++;
      mem_rvalid = 1'b0;
      chk(in_ready == !(active && !done), "R1 in_ready", 64'(in_ready), 64'(!(active && !done)));
      if (done) begin
        chk(active, "R10 done without walk", 64'(done), 64'h0);
        chk(pte == exp_pte, cur_tag, pte, exp_pte);
        chk(cyc == ev_cyc + (exp_oob ? 2 : 1), {cur_tag, " timing"}, 64'(cyc), 64'(ev_cyc + (exp_oob ? 2 : 1)));
        chk(exp_q.size() == 0, "R3 missing requests", 64'(exp_q.size()), 64'h0);
        active = 1'b0;
      end else begin
        chk(pte == '0, "R10 pte idle", pte, 64'h0);
      end
      if (mem_req) begin
        chk(!pending, "R11 second outstanding read", 64'(pending), 64'h0);
        chk(exp_q.size() > 0 && mem_addr == exp_q[0], "R3 request address", mem_addr,
            (exp_q.size() > 0) ? exp_q[0] : 64'hX);
        chk(cyc == ev_cyc + 1, "R6 request timing", 64'(cyc), 64'(ev_cyc + 1));
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        pending   = 1'b1;
        resp_cyc  = cyc + lat;
        resp_data = rd(mem_addr);
      end
      if (pending && cyc == resp_cyc) begin
        mem_rvalid = 1'b1;
        mem_rdata  = resp_data;
        pending    = 1'b0;
        ev_cyc     = cyc;
      end
    end
  end

  task automatic run(input logic [63:0] va, input logic [63:0] root, input int l,
                     input bit hammer, input string tag);
    @(negedge clk); #1;
    while (!in_ready) begin @(negedge clk); #1; end
    in_valid = 1'b1;
    in_vaddr = va;
    pt_root  = root;
    lat      = l;
    cur_tag  = tag;
    ref_walk(va, root);
    ev_cyc   = cyc;
    active   = 1'b1;
    @(negedge clk); #1;
    if (hammer) begin
      // R1: changes while busy must not disturb the walk
      in_vaddr = va ^ 64'h0000_0000_4020_1000;
      pt_root  = root + 64'h2000;
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
    while (active) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // page tables, root at 0x1000
    mem_img[64'h1008] = 64'h2003;       // level 0 -> table at 0x2000
    mem_img[64'h2008] = 64'h3003;       // level 1 -> table at 0x3000
    mem_img[64'h3018] = 64'h5_0001;     // 4 KiB leaf
    mem_img[64'h2010] = 64'hC_0001;     // 2 MiB leaf
    mem_img[64'h1010] = 64'h1;          // 1 GiB leaf at base 0
    mem_img[64'h1018] = 64'h1;          // 1 GiB leaf, fold overflows
    mem_img[64'h1028] = 64'h4003;
    mem_img[64'h4000] = 64'h5003;
    mem_img[64'h5000] = 64'h6003;       // table at last level
    mem_img[64'h1030] = 64'h10_0003;    // next table at memory end
    mem_img[64'h1800] = 64'h7001;       // upper-half address leaf

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset in_ready", 64'(in_ready), 64'h1);
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'h0);
    chk(mem_req == 1'b0, "R1 reset mem_req", 64'(mem_req), 64'h0);
    live = 1'b1;

    run(64'h0000_0000_4020_3ABC, 64'h1000, 1, 1'b0, "R7 4K leaf");
    run(64'h0000_0000_4040_5123, 64'h1000, 3, 1'b0, "R7 2M leaf fold");
    run(64'h0000_0000_8003_4000, 64'h1000, 2, 1'b0, "R7 1G leaf fold");
    run(64'h0000_0000_C020_0000, 64'h1000, 1, 1'b0, "R8 folded page past end");
    run(64'h0000_0001_0000_0000, 64'h1000, 2, 1'b0, "R5 invalid entry");
    run(64'h0000_0001_4000_0000, 64'h1000, 1, 1'b0, "R9 table at last level");
    run(64'h0000_0001_8000_0000, 64'h1000, 2, 1'b0, "R4 entry address at end");
    run(64'h0000_0040_0000_0000, 64'h1000, 1, 1'b0, "R2 non-canonical");
    run(64'hFFFF_FF80_0000_0000, 64'h1000, 1, 1'b0, "R2 non-canonical high");
    run(64'hFFFF_FFC0_0000_1000, 64'h1000, 2, 1'b0, "R2 canonical upper half");
    run(64'h0000_0000_0000_0000, 64'h10_0000, 1, 1'b0, "R4 root at end");
    run(64'h0000_0000_4020_3ABC, 64'h1000, 3, 1'b1, "R1 inputs ignored while busy");
    run(64'h0000_0000_4040_5123, 64'h1000, 3, 1'b1, "R6 ignored inputs superpage");

    // R11: stray data-valid while idle must not produce a result
    @(negedge clk); #1;
    mem_rdata  = 64'h9001;
    mem_rvalid = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b1, "R11 stray rvalid", 64'(done), 64'h0);

    run(64'h0000_0000_4020_3ABC, 64'h1000, 1, 1'b0, "R7 after stray");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule